// File: doc/BRIEF.md
# ADC result register file with interrupt logic

This block holds the conversion results of an eight-channel analog converter and raises its interrupt. The converter reports each finished conversion on a one-cycle strobe. The strobe carries a channel number, a 10-bit value and a flag that says whether the converter is in burst mode. The block stores the value in that channel's data word and sets the channel's completion flag. If an unread result is replaced during burst mode, it also sets the channel's overrun flag. A global data word always follows the newest result and records which channel produced it.

Software uses a simple word bus. Each access is one cycle, and read data is valid in the same cycle as the select. Reading a data word clears that word's flags at the end of the cycle. The read itself still returns the flags as they were before the clear. A status word shows all per-channel flags in a single read. An enable word picks which completions drive the single level interrupt output.

Top module: `adcr_result_regs`

## Requirements
- R1: Word address 3+n (n = 0..7) is channel n's data word. The result sits in bits 15:6, and bits 5:0 and 29:16 read as zero.
- R2: Bit 31 of a channel data word (done) is set by a result for that channel. A read of that word with no result for the channel in the same cycle clears it.
- R3: Bit 30 of a channel data word (overrun) is set when a burst result (burst flag 1) arrives while done is still set and the word is not being read in that cycle. A read of the word clears it.
- R4: A non-burst result (burst flag 0) that replaces an unread result leaves overrun unchanged.
- R5: If a result and a read hit the same data word in one cycle, the read returns the old contents. After that cycle the word holds the new result, done is 1 and overrun is 0.
- R6: Word address 0 is the global data word:
  - bits 15:6 hold the newest result of any channel;
  - bits 26:24 hold its channel number;
  - bit 30 is the global overrun flag and bit 31 is the global done flag, both following the same rules as R2, R3 and R4;
  - all other bits read as zero;
  - reading it clears only its own two flags.
- R7: Word address 2 is the status word. Bits 7:0 are the channel done flags and bits 15:8 the channel overrun flags (bit 8+n for channel n). Bit 16 is the OR of the channel done flags, and bits 31:17 read as zero. Reading it changes nothing.
- R8: Word address 1 is the interrupt enable word. Bits 7:0 are per-channel enables and reset to 0. Bit 8 is the global enable and resets to 1. Bits 31:9 read as zero. A write loads bits 8:0, and a read changes nothing.
- R9: `irq` is high exactly when some channel n has done and enable n both set, or when the global done flag and the global enable are both set.
- R10: Writes to data or status words are ignored. Reads of addresses 11 to 15 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the select |
| res_valid | input | 1 | Conversion result strobe |
| res_chan | input | 3 | Channel of the result |
| res_data | input | 10 | Result value |
| res_burst | input | 1 | Result was produced in burst mode |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: eight channels and 10-bit results. At that size every channel slot, the full status word and all enable bits can be reached within a few thousand random cycles. The random mix often puts a result and a read on the same word in one cycle. It also often produces back-to-back burst and non-burst results on an unread channel. The collision, overrun and masked-interrupt cases therefore come up many times, on top of the directed sequences.

// File: rtl/adcr_pkg.sv
package adcr_pkg;
  localparam int BUS_W         = 32;
  localparam int RES_LSB       = 6;
  localparam int CHAN_LSB      = 24;
  localparam int OVR_BIT       = 30;
  localparam int DONE_BIT      = 31;
  localparam int ADDR_GLOBAL   = 0;
  localparam int ADDR_INTEN    = 1;
  localparam int ADDR_STATUS   = 2;
  localparam int ADDR_CH_BASE  = 3;
endpackage

// File: rtl/adcr_rst_sync.sv
module adcr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/adcr_slot.sv
module adcr_slot #(
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_en,
  input  logic          res_burst,
  input  logic [PW-1:0] res_payload,
  input  logic          rd_en,
  output logic [PW-1:0] payload_o,
  output logic          done_o,
  output logic          ovr_o
);
  logic          upd;
  logic          done_n;
  logic          ovr_n;
  logic [PW-1:0] payload_n;

  always_comb begin
    upd       = res_en | rd_en;
    done_n    = res_en | (done_o & ~rd_en);
    ovr_n     = (ovr_o & ~rd_en) | (res_en & res_burst & done_o & ~rd_en);
    payload_n = res_en ? res_payload : payload_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o    <= 1'b0;
      ovr_o     <= 1'b0;
      payload_o <= '0;
    end else if (upd) begin
      done_o    <= done_n;
      ovr_o     <= ovr_n;
      payload_o <= payload_n;
    end
  end

  assert_done_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_en |=> done_o);
  assert_done_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !res_en) |=> (!done_o && !ovr_o));
  assert_ovr_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_en && res_burst && done_o && !rd_en) |=> ovr_o);
  assert_ovr_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_en && !res_burst && !rd_en) |=> (ovr_o == $past(ovr_o)));
  assert_collide_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_en && rd_en) |=> (done_o && !ovr_o && payload_o == $past(res_payload)));
endmodule

// File: rtl/adcr_irq.sv
module adcr_irq #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [NUM_CH:0]   wdata,
  input  logic [NUM_CH-1:0] ch_done,
  input  logic              glob_done,
  output logic [NUM_CH-1:0] mask_o,
  output logic              gen_o,
  output logic              irq
);
  logic [NUM_CH-1:0] mask_n;
  logic              gen_n;

  always_comb begin
    mask_n = wr_en ? wdata[NUM_CH-1:0] : mask_o;
    gen_n  = wr_en ? wdata[NUM_CH]     : gen_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o <= '0;
      gen_o  <= 1'b1;
    end else if (wr_en) begin
      mask_o <= mask_n;
      gen_o  <= gen_n;
    end
  end

  assign irq = (|(ch_done & mask_o)) | (glob_done & gen_o);

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((|ch_done) || glob_done));
  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_o == '0 && !gen_o) |-> !irq);
  assert_en_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (gen_o == $past(wdata[NUM_CH])));
endmodule

// File: rtl/adcr_result_regs.sv
module adcr_result_regs
  import adcr_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10,
  parameter int ADDR_W = 4,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              res_valid,
  input  logic [CH_W-1:0]   res_chan,
  input  logic [RES_W-1:0]  res_data,
  input  logic              res_burst,
  output logic              irq
);
  localparam int GPW = CH_W + RES_W;

  logic              rst_sync_n;
  logic              rd_hit;
  logic              wr_hit;
  logic [NUM_CH-1:0] ch_done;
  logic [NUM_CH-1:0] ch_ovr;
  logic [RES_W-1:0]  ch_res [NUM_CH];
  logic [GPW-1:0]    g_payload;
  logic              g_done;
  logic              g_ovr;
  logic [NUM_CH-1:0] en_mask;
  logic              en_glob;
  logic              data_addr;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata[BUS_W-1:NUM_CH+1];

  adcr_rst_sync i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign rd_hit = bus_sel & ~bus_wr;
  assign wr_hit = bus_sel &  bus_wr;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic res_here;
    logic rd_here;
    assign res_here = res_valid & (res_chan == CH_W'(n));
    assign rd_here  = rd_hit & (bus_addr == ADDR_W'(ADDR_CH_BASE + n));

    adcr_slot #(.PW(RES_W)) i_slot (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .res_en      (res_here),
      .res_burst   (res_burst),
      .res_payload (res_data),
      .rd_en       (rd_here),
      .payload_o   (ch_res[n]),
      .done_o      (ch_done[n]),
      .ovr_o       (ch_ovr[n])
    );
  end

  adcr_slot #(.PW(GPW)) i_glob (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .res_en      (res_valid),
    .res_burst   (res_burst),
    .res_payload ({res_chan, res_data}),
    .rd_en       (rd_hit & (bus_addr == ADDR_W'(ADDR_GLOBAL))),
    .payload_o   (g_payload),
    .done_o      (g_done),
    .ovr_o       (g_ovr)
  );

  adcr_irq #(.NUM_CH(NUM_CH)) i_irq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_hit & (bus_addr == ADDR_W'(ADDR_INTEN))),
    .wdata     (bus_wdata[NUM_CH:0]),
    .ch_done   (ch_done),
    .glob_done (g_done),
    .mask_o    (en_mask),
    .gen_o     (en_glob),
    .irq       (irq)
  );

  always_comb begin
    bus_rdata = '0;
    data_addr = 1'b0;
    if (bus_addr == ADDR_W'(ADDR_GLOBAL)) begin
      bus_rdata[RES_LSB +: RES_W] = g_payload[RES_W-1:0];
      bus_rdata[CHAN_LSB +: CH_W] = g_payload[GPW-1:RES_W];
      bus_rdata[OVR_BIT]          = g_ovr;
      bus_rdata[DONE_BIT]         = g_done;
      data_addr                   = 1'b1;
    end else if (bus_addr == ADDR_W'(ADDR_INTEN)) begin
      bus_rdata[NUM_CH-1:0] = en_mask;
      bus_rdata[NUM_CH]     = en_glob;
    end else if (bus_addr == ADDR_W'(ADDR_STATUS)) begin
      bus_rdata[NUM_CH-1:0]        = ch_done;
      bus_rdata[2*NUM_CH-1:NUM_CH] = ch_ovr;
      bus_rdata[2*NUM_CH]          = |ch_done;
    end else begin
      for (int n = 0; n < NUM_CH; n++) begin
        if (bus_addr == ADDR_W'(ADDR_CH_BASE + n)) begin
          bus_rdata[RES_LSB +: RES_W] = ch_res[n];
          bus_rdata[OVR_BIT]          = ch_ovr[n];
          bus_rdata[DONE_BIT]         = ch_done[n];
          data_addr                   = 1'b1;
        end
      end
    end
  end

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    data_addr |-> (bus_rdata[RES_LSB-1:0] == '0 && bus_rdata[CHAN_LSB-1:RES_LSB+RES_W] == '0));
  assert_status_or_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr == ADDR_W'(ADDR_STATUS)) |-> (bus_rdata[2*NUM_CH] == (bus_rdata[NUM_CH-1:0] != '0)));
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr >= ADDR_W'(ADDR_CH_BASE + NUM_CH)) |-> (bus_rdata == '0));
endmodule

// File: tb/test_adcr_result_regs.sv
module test_adcr_result_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        res_valid;
  logic [2:0]  res_chan;
  logic [9:0]  res_data;
  logic        res_burst;
  logic        irq;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    finished = 0;
  string tag_ovr  = "";

  logic [7:0] m_done, m_ovr, m_mask;
  logic       m_gen, m_gdone, m_govr;
  logic [9:0] m_data [8];
  logic [9:0] m_gdat;
  logic [2:0] m_gch;

  always #(CLK_PERIOD/2) clk = ~clk;

  adcr_result_regs i_adcr_result_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data),
    .res_burst(res_burst), .irq(irq)
  );

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    logic [31:0] v = '0;
    if (a == 0)       v = {m_gdone, m_govr, 3'b0, m_gch, 8'b0, m_gdat, 6'b0};
    else if (a == 1)  v = {23'b0, m_gen, m_mask};
    else if (a == 2)  v = {15'b0, |m_done, m_ovr, m_done};
    else if (a <= 10) v = {m_done[a-3], m_ovr[a-3], 14'b0, m_data[a-3], 6'b0};
    return v;
  endfunction

  function automatic logic exp_irq();
    return (|(m_done & m_mask)) | (m_gdone & m_gen);
  endfunction

  function automatic string tag_for(input logic [3:0] a);
    if (tag_ovr != "") return tag_ovr;
    if (a == 0) return "R6";
    if (a == 1) return "R8";
    if (a == 2) return "R7";
    if (a <= 10) return "R1,R2,R3";
    return "R10";
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_done = '0; m_ovr = '0; m_mask = '0; m_gen = 1'b1;
    m_gdone = 1'b0; m_govr = 1'b0; m_gdat = '0; m_gch = '0;
    for (int n = 0; n < 8; n++) m_data[n] = '0;
  endtask

  task automatic step(input logic s, input logic w, input logic [3:0] a,
                      input logic [31:0] wd, input logic rv, input logic [2:0] ch,
                      input logic [9:0] d, input logic b);
    logic rd, rdn;
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = wd;
    res_valid = rv; res_chan = ch; res_data = d; res_burst = b;
    #1;
    if (s && !w) check(tag_for(a), bus_rdata, exp_read(a));
    check("R9", {31'b0, irq}, {31'b0, exp_irq()});
    rd = s && !w;
    for (int n = 0; n < 8; n++) begin
      rdn = rd && (a == 4'(n + 3));
      if (rv && ch == 3'(n)) begin
        m_ovr[n]  = (m_ovr[n] & !rdn) | (b & m_done[n] & !rdn);
        m_done[n] = 1'b1;
        m_data[n] = d;
      end else if (rdn) begin
        m_done[n] = 1'b0; m_ovr[n] = 1'b0;
      end
    end
    rdn = rd && (a == 0);
    if (rv) begin
      m_govr  = (m_govr & !rdn) | (b & m_gdone & !rdn);
      m_gdone = 1'b1; m_gdat = d; m_gch = ch;
    end else if (rdn) begin
      m_gdone = 1'b0; m_govr = 1'b0;
    end
    if (s && w && a == 1) begin
      m_mask = wd[7:0]; m_gen = wd[8];
    end
    @(negedge clk);
  endtask

  task automatic rd_word(input logic [3:0] a);
    step(1, 0, a, 0, 0, 0, 0, 0);
  endtask

  task automatic result(input logic [2:0] ch, input logic [9:0] d, input logic b);
    step(0, 0, 0, 0, 1, ch, d, b);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_errors++; n_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'd4242);
    rst_n = 1'b0;
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    res_valid = 0; res_chan = 0; res_data = 0; res_burst = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset values R8, R7, R6
    tag_ovr = "R8"; rd_word(1);
    tag_ovr = "R7"; rd_word(2);
    tag_ovr = "R6"; rd_word(0);
    tag_ovr = "R1"; rd_word(3);

    // R2: set then clear on read
    result(3'd4, 10'h2A5, 0);
    tag_ovr = "R2"; rd_word(7); rd_word(7);

    // R4: non-burst overwrite does not set overrun
    result(3'd2, 10'h011, 0); result(3'd2, 10'h022, 0);
    tag_ovr = "R4"; rd_word(5);

    // R3: burst overwrite sets overrun, read clears
    result(3'd5, 10'h100, 1); result(3'd5, 10'h3FF, 1);
    tag_ovr = "R3"; rd_word(2); rd_word(8); rd_word(8);

    // R5: result and read on same word in one cycle
    result(3'd1, 10'h155, 1);
    tag_ovr = "R5";
    step(1, 0, 4'd4, 0, 1, 3'd1, 10'h2AA, 1);
    rd_word(4);

    // R6: global read clears only its own flags
    result(3'd6, 10'h0F0, 0);
    tag_ovr = "R6"; rd_word(0); rd_word(0);
    tag_ovr = "R7"; rd_word(2);
    rd_word(9);

    // R10: writes to data/status ignored, unmapped reads zero
    result(3'd0, 10'h123, 0);
    step(1, 1, 4'd3, 32'hFFFF_FFFF, 0, 0, 0, 0);
    step(1, 1, 4'd2, 32'hFFFF_FFFF, 0, 0, 0, 0);
    step(1, 1, 4'd0, 32'hFFFF_FFFF, 0, 0, 0, 0);
    tag_ovr = "R10"; rd_word(2); rd_word(3); rd_word(11); rd_word(15);

    // R9: mask combinations
    tag_ovr = "R8";
    step(1, 1, 4'd1, 32'hFFFF_FE00, 0, 0, 0, 0); rd_word(1);
    result(3'd3, 10'h001, 0);
    step(1, 1, 4'd1, 32'h0000_0008, 0, 0, 0, 0);
    rd_word(0);
    step(1, 1, 4'd1, 32'h0000_0004, 0, 0, 0, 0);
    step(1, 1, 4'd1, 32'h0000_0100, 0, 0, 0, 0);
    result(3'd7, 10'h3C3, 1);
    rd_word(10); rd_word(0);
    tag_ovr = "";

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      logic s, w, rv, b;
      logic [3:0] a;
      s  = ($urandom % 2) == 0;
      w  = ($urandom % 10) == 0;
      a  = (($urandom % 8) == 0) ? 4'($urandom % 16) : 4'($urandom % 11);
      rv = ($urandom % 2) == 0;
      b  = ($urandom % 2) == 0;
      step(s, w, a, $urandom, rv, 3'($urandom % 8), 10'($urandom), b);
    end

    finish_run();
  end
endmodule